// File: doc/BRIEF.md
# PHY Test-Control Register Interface

This block is a slave that sits behind three host-driven test wires inside a PHY: a slow test clock, a test enable and an 8-bit test data input. Through them a host selects one register in a sparse 12-bit configuration address space and reads or writes it 8 bits at a time. The selected register is always visible on the 8-bit test data output. A clear input returns the whole interface to its reset state.

A falling test-clock edge with enable high captures a code byte. A rising test-clock edge with enable low writes a data byte. The code byte 0x00 is a prefix: the data write that follows it loads the upper four address bits and touches no register. Any other code byte becomes the lower eight address bits, joined with the stored upper nibble. The test clock, enable, data and clear are sampled into the system clock domain through two-flop synchronizers, and the edges are found there. The host must therefore hold each wire level for several system clocks.

Top module: `ptc_regif`

## Requirements
- R1: After reset the test data output is 0x00, and every register, the stored upper nibble and the code byte are 0x00.
- R2: A falling test-clock edge while test enable is high captures the test data input as the code byte. The output then shows the register at {upper nibble, code byte} with no further test-clock edge.
- R3: A rising test-clock edge while test enable is low, with a nonzero code byte, writes the test data input into the register at {upper nibble, code byte}.
- R4: When the code byte is 0x00, the next rising-edge data write loads test data input bits [3:0] as address bits [11:8] and leaves every register unchanged.
- R5: The address is the full 12 bits. With upper nibble 0x1, the code byte 0xE1 selects 0x1E1, which is unimplemented and distinct from 0x0E1.
- R6: Registers exist at 0x001, 0x002, 0x008 and 0x0E0 to 0x0E4. Each of the eight holds its own value.
- R7: Reads of any other address return 0x00. Writes to such an address change no register.
- R8: A rising test-clock edge with enable high writes nothing. A falling edge with enable low leaves the code byte unchanged.
- R9: Raising the clear input and releasing it returns all registers, the upper nibble and the code byte to 0x00, so the output reads 0x00.
- R10: The upper nibble keeps its value across any number of code captures and data writes until a new prefix write loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tst_clk | input | 1 | Host test clock, asynchronous to clk |
| tst_en | input | 1 | Host test enable: high marks a code phase, low marks a data phase |
| tst_din | input | 8 | Host test data input |
| tst_clr | input | 1 | Clear, active high |
| tst_dout | output | 8 | Contents of the addressed register, 0x00 if unimplemented |

## Verification
A change on any test wire passes two synchronizer flops and one edge-history flop. The code byte, the upper nibble and the registers therefore settle on the third system clock edge after the change, and the output follows with no further delay. The same three-edge rule covers the clear. The driver changes wires only on falling system-clock edges and holds every level for four system clocks. It pushes each expected output value only after the step that selects the register. The monitor compares at that falling edge, after the result has settled and before the next wire change.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 12;
  localparam int HI_W     = ADDR_W - DATA_W;
  localparam int NUM_REGS = 8;
  localparam int SLOT_W   = $clog2(NUM_REGS);
  localparam int RUN_BASE = 3;
  localparam logic [ADDR_W-1:0] RUN_START = 12'h0E0;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_sel_t;

  // Address held by register slot i.
  function automatic logic [ADDR_W-1:0] reg_addr(input int i);
    logic [ADDR_W-1:0] a;
    case (i)
      0:       a = 12'h001;
      1:       a = 12'h002;
      2:       a = 12'h008;
      default: a = RUN_START + ADDR_W'(i - RUN_BASE);
    endcase
    return a;
  endfunction

  // Turns a 12-bit address into a hit flag and a slot number.
  function automatic slot_sel_t map_addr(input logic [ADDR_W-1:0] a);
    slot_sel_t r;
    r.hit  = 1'b0;
    r.slot = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (a == reg_addr(i)) begin
        r.hit  = 1'b1;
        r.slot = SLOT_W'(i);
      end
    end
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [HI_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/ptc_sync.sv
module ptc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ptc_edge.sv
module ptc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_s,
  input  logic en_s,
  input  logic clr_s,
  output logic code_evt,
  output logic data_evt
);
  logic clk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_d <= 1'b0;
    else        clk_d <= clk_s;
  end

  logic fall_seen, rise_seen;
  assign fall_seen = clk_d & ~clk_s;
  assign rise_seen = ~clk_d & clk_s;

  // The clear input suppresses every event while it is high.
  assign code_evt = fall_seen &  en_s & ~clr_s;
  assign data_evt = rise_seen & ~en_s & ~clr_s;
endmodule

// File: rtl/ptc_addr_ctl.sv
module ptc_addr_ctl
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_s,
  input  logic              code_evt,
  input  logic              data_evt,
  input  logic [DATA_W-1:0] din_s,
  output logic [DATA_W-1:0] code_q,
  output logic [HI_W-1:0]   upper_q,
  output logic              pfx_wr,
  output logic              reg_we,
  output logic              addr_hit,
  output logic [SLOT_W-1:0] addr_slot
);
  logic              code_is_pfx;
  logic [ADDR_W-1:0] full_addr;
  slot_sel_t         sel;

  assign code_is_pfx = (code_q == '0);
  assign full_addr   = join_addr(upper_q, code_q);
  assign sel         = map_addr(full_addr);
  assign addr_hit    = sel.hit;
  assign addr_slot   = sel.slot;
  assign pfx_wr      = data_evt &  code_is_pfx;
  assign reg_we      = data_evt & ~code_is_pfx & sel.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      upper_q <= '0;
    end else if (clr_s) begin
      code_q  <= '0;
      upper_q <= '0;
    end else begin
      if (code_evt) code_q  <= din_s;
      if (pfx_wr)   upper_q <= din_s[HI_W-1:0];
    end
  end
endmodule

// File: rtl/ptc_regfile.sv
module ptc_regfile
  import ptc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_s,
  input  logic              we,
  input  logic              hit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (clr_s)                             regs[g] <= '0;
      else if (we && (slot == SLOT_W'(g)))        regs[g] <= wdata;
    end
  end

  assign rdata = hit ? regs[slot] : '0;
endmodule

// File: rtl/ptc_regif.sv
module ptc_regif
  import ptc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tst_clk,
  input  logic              tst_en,
  input  logic [DATA_W-1:0] tst_din,
  input  logic              tst_clr,
  output logic [DATA_W-1:0] tst_dout
);
  localparam int SYNC_W = DATA_W + 3;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic              clk_s, en_s, clr_s;
  logic [DATA_W-1:0] din_s;

  assign raw_bus = {tst_clr, tst_en, tst_clk, tst_din};
  assign {clr_s, en_s, clk_s, din_s} = sync_bus;

  ptc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  logic code_evt, data_evt;

  ptc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .clk_s(clk_s), .en_s(en_s), .clr_s(clr_s),
    .code_evt(code_evt), .data_evt(data_evt)
  );

  logic [DATA_W-1:0] code_q;
  logic [HI_W-1:0]   upper_q;
  logic              pfx_wr, reg_we, addr_hit;
  logic [SLOT_W-1:0] addr_slot;

  ptc_addr_ctl u_addr (
    .clk(clk), .rst_n(rst_n), .clr_s(clr_s),
    .code_evt(code_evt), .data_evt(data_evt), .din_s(din_s),
    .code_q(code_q), .upper_q(upper_q), .pfx_wr(pfx_wr),
    .reg_we(reg_we), .addr_hit(addr_hit), .addr_slot(addr_slot)
  );

  ptc_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .clr_s(clr_s),
    .we(reg_we), .hit(addr_hit), .slot(addr_slot),
    .wdata(din_s), .rdata(tst_dout)
  );
endmodule

// File: rtl/ptc_regif_chk.sv
module ptc_regif_chk
  import ptc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clr_s,
  input logic              code_evt,
  input logic              data_evt,
  input logic [DATA_W-1:0] din_s,
  input logic [DATA_W-1:0] code_q,
  input logic [HI_W-1:0]   upper_q,
  input logic              reg_we,
  input logic              addr_hit,
  input logic [DATA_W-1:0] dout
);
  a_r2_code_latch: assert property (@(posedge clk) disable iff (!rst_n)
    code_evt |=> code_q == $past(din_s));

  a_r4_prefix_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && code_q == '0) |-> !reg_we);

  a_r4_prefix_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && code_q == '0) |=> upper_q == $past(din_s[HI_W-1:0]));

  a_r10_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(data_evt && code_q == '0) && !clr_s) |=> $stable(upper_q));

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> dout == '0);

  a_r3_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> dout == $past(din_s));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (dout == '0 && code_q == '0 && upper_q == '0));
endmodule

bind ptc_regif ptc_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_s(clr_s),
  .code_evt(code_evt), .data_evt(data_evt), .din_s(din_s),
  .code_q(code_q), .upper_q(upper_q), .reg_we(reg_we),
  .addr_hit(addr_hit), .dout(tst_dout)
);

// File: tb/ptc_regif_test.sv
`timescale 1ns/1ps
module ptc_regif_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tck = 1'b0, ten = 1'b0, tclr = 1'b0;
  logic [7:0] tdin = 8'h00;
  logic [7:0] tdout;

  always #10 clk = ~clk;

  ptc_regif uut (
    .clk(clk), .rst_n(rst_n), .tst_clk(tck), .tst_en(ten),
    .tst_din(tdin), .tst_clr(tclr), .tst_dout(tdout)
  );

  typedef struct { string tag; logic [7:0] exp; } item_t;
  item_t q[$];
  event  smp;
  int    total = 0, bad = 0;
  logic [7:0] mdl [int];

  function automatic bit is_impl(input int a);
    return a == 12'h001 || a == 12'h002 || a == 12'h008 ||
           (a >= 12'h0E0 && a <= 12'h0E4);
  endfunction

  function automatic logic [7:0] mdl_get(input int a);
    if (is_impl(a) && mdl.exists(a)) return mdl[a];
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: dout=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(smp);
      it = q.pop_front();
      check(it.tag, tdout, it.exp);
    end
  end

  task automatic hold(); repeat (4) @(negedge clk); endtask

  task automatic expect_now(input string tag, input logic [7:0] exp);
    item_t it;
    it.tag = tag; it.exp = exp;
    q.push_back(it);
    -> smp;
    @(negedge clk);
  endtask

  task automatic cap_code(input logic [7:0] b);
    ten = 1'b1; hold(); tck = 1'b1; hold(); tdin = b; hold();
    tck = 1'b0; hold(); ten = 1'b0; hold();
  endtask

  task automatic put_data(input logic [7:0] b);
    tdin = b; hold(); tck = 1'b1; hold(); tck = 1'b0; hold();
  endtask

  task automatic select(input int a);
    cap_code(8'h00); put_data(8'(a >> 8)); cap_code(8'(a));
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    select(a); put_data(d);
    if (is_impl(a)) mdl[a] = d;
  endtask

  task automatic rd(input int a, input string tag);
    select(a); expect_now(tag, mdl_get(a));
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: dout=%02h expected=done", tdout);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    int addrs [8] = '{12'h001, 12'h002, 12'h008, 12'h0E0,
                      12'h0E1, 12'h0E2, 12'h0E3, 12'h0E4};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold();
    expect_now("R1 reset output", 8'h00);
    rd(12'h0E4, "R1 register after reset");

    for (int i = 0; i < 8; i++) wr(addrs[i], 8'(8'h11 * (i + 1)));
    rd(12'h001, "R2 read without extra clock");
    for (int i = 0; i < 8; i++) rd(addrs[i], "R6 independent register");
    wr(12'h0E2, 8'hC3);
    rd(12'h0E2, "R3 overwrite");

    wr(12'h003, 8'hAA);
    rd(12'h003, "R7 unimplemented read");
    wr(12'h0E5, 8'hBB);
    rd(12'h0E5, "R7 unimplemented 0x0E5");
    rd(12'h002, "R7 neighbour unchanged");
    rd(12'h0E4, "R7 neighbour 0x0E4 unchanged");

    wr(12'h1E1, 8'hFF);
    rd(12'h1E1, "R5 upper nibble selects 0x1E1");
    rd(12'h0E1, "R5 0x0E1 unchanged");

    select(12'h0E2);
    cap_code(8'h00); put_data(8'h01);
    cap_code(8'hE2);
    expect_now("R4 prefix moved address to 0x1E2", 8'h00);
    rd(12'h0E2, "R4 prefix write left register");

    select(12'h001);
    cap_code(8'h08);
    expect_now("R10 nibble kept across codes", mdl_get(12'h008));
    put_data(8'h5C); mdl[12'h008] = 8'h5C;
    expect_now("R10 write without new prefix", 8'h5C);
    cap_code(8'hE0);
    expect_now("R10 nibble kept after write", mdl_get(12'h0E0));

    select(12'h001);
    ten = 1'b1; hold(); tdin = 8'h5A; hold(); tck = 1'b1; hold();
    expect_now("R8 rise with enable high no write", mdl_get(12'h001));
    ten = 1'b0; hold(); tck = 1'b0; hold();
    expect_now("R8 fall with enable low keeps code", mdl_get(12'h001));
    rd(12'h001, "R8 register intact");

    tclr = 1'b1; hold(); tclr = 1'b0; hold();
    mdl.delete();
    expect_now("R9 output after clear", 8'h00);
    rd(12'h001, "R9 0x001 cleared");
    rd(12'h0E3, "R9 0x0E3 cleared");

    hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule